// File: doc/BRIEF.md
# Shared Host Bus Pin Port

This block sits between twelve package pins and the rest of a device. It lets the pins act either as an 8-bit parallel host bus or as twelve general-purpose I/O bits. In host mode an external processor uses an active-low enable, a read/write line and three address lines to read or write one of eight internal registers. A DMA controller can also pull data off the bus with an active-low acknowledge while the block's active-low request is asserted. In GPIO mode the same pins are set, bit by bit, by a direction register and an output data register. The registers that host accesses reach, and the source of the request, sit outside this block. They meet it through a plain register read port and a one-cycle write strobe.

Pin bits are assigned as follows: bits 7..0 carry the data byte, bits 10..8 the register address and bit 11 read/write (1 = read). Every asynchronous pin input passes through two flip-flops before any decision is made. Two state machines drive the behaviour. The mode machine has the states MODE_GPIO, MODE_BLANK and MODE_HOST. Its transitions are GPIO to BLANK and HOST to BLANK when software writes the other mode, then BLANK to the written target after one cycle. The access machine has the states ACC_IDLE, ACC_READ, ACC_WRITE and ACC_DMA:
- IDLE goes to READ on an enable with read/write high, to WRITE on an enable with read/write low, and to DMA on an acknowledge while a request is pending. The enable takes priority.
- READ and WRITE return to IDLE when the enable rises.
- DMA returns to IDLE when the acknowledge rises.
- Any state returns to IDLE when host mode is left.

Software configures the block through a small register port: address 0 holds the mode bit (bit 0, 1 = host), address 1 the direction register (1 = output), and address 2 the output data register.

Top module: `host_pin_port`

## Requirements
- R1: After reset every pad output enable is low, the mode reads back as GPIO (configuration address 0 returns 0), and the host request output is high.
- R2: In host mode, an enabled access with read/write high makes the block drive pad bits 7..0 with the register read data. The register read address is the three address bits sampled at the start of the access. Pad bits 11..8 are never driven in host mode.
- R3: In host mode, an enabled access with read/write low leaves the data pins undriven. When the enable rises, exactly one single-cycle write strobe is issued, carrying the latched address and the data byte present on the pads when the enable rose.
- R4: In host mode, with the enable high and no acknowledged request, no pad is driven.
- R5: An acknowledge low while the request output is low drives pad bits 7..0 with read data, with no enable needed. An acknowledge while no request is pending has no effect on the pads.
- R6: The three address pad bits pick any of the eight registers, including addresses 0 and 7.
- R7: If read/write changes during an enabled access, the protocol error output is high in each cycle where the synchronized read/write differs from the direction latched at the start. The access keeps its original direction.
- R8: In GPIO mode each pad's output enable equals its direction bit and each pad output equals its output data bit. Host enable and read/write have no effect on the pads.
- R9: Reading configuration address 2 returns, for each bit, the output data bit when that pin is an output, and the synchronized pin level when it is an input.
- R10: A write that changes the mode bit forces every pad output enable low for exactly one cycle before the new mode takes over.
- R11: The pads begin driving on the third rising clock edge after the host enable falls, never earlier.
- R12: The request output is low exactly when host mode is active and the internal request input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_i | input | 12 | Pin input levels: [7:0] data, [10:8] address, [11] read/write |
| pad_o | output | 12 | Pin output values |
| pad_oe | output | 12 | Pin output enables, 1 = driven |
| hen_n | input | 1 | Host enable, active low |
| hack_n | input | 1 | DMA acknowledge, active low |
| hreq_n | output | 1 | Host request, active low |
| req_pend | input | 1 | Internal request pending |
| reg_rd_addr | output | 3 | Register read address toward the internal registers |
| reg_rd_data | input | 8 | Register read data for the selected address |
| reg_wr_stb | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 3 | Register write address |
| reg_wr_data | output | 8 | Register write byte |
| proto_err | output | 1 | Read/write changed during an access |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 12 | Configuration write data |
| cfg_rdata | output | 12 | Configuration read data |

## Verification
Several properties are checked on every cycle by the assertions:
- a write strobe lasts one cycle and only follows a low enable;
- the data pins drive only after an enable or an acknowledge was seen;
- a protocol error is only reported inside an enabled access;
- a mode change always passes through exactly one blanked cycle with no pad driven.

Other properties only the directed scenarios can show: the exact three-edge latency, the read data and address seen on the pads, the captured write byte, the mixed pin and latch readback in GPIO mode, and whether an acknowledge without a request is really ignored.

// File: rtl/hpp_pkg.sv
`timescale 1ns/1ps
package hpp_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_DMA   = 2'd3
    } acc_state_e;

    typedef enum logic [1:0] {
        MODE_GPIO  = 2'd0,
        MODE_BLANK = 2'd1,
        MODE_HOST  = 2'd2
    } mode_state_e;

    localparam logic [1:0] CFG_MODE = 2'd0;
    localparam logic [1:0] CFG_DIR  = 2'd1;
    localparam logic [1:0] CFG_DATA = 2'd2;
endpackage

// File: rtl/hpp_sync.sv
`timescale 1ns/1ps
module hpp_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= RST_VAL;
                    else        stg[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= RST_VAL;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/hpp_access_fsm.sv
`timescale 1ns/1ps
module hpp_access_fsm
    import hpp_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_sel,
    input  logic          en_s,
    input  logic          ack_s,
    input  logic          rw_s,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    input  logic          req_pend,
    output logic          drive,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [AW-1:0] rd_addr,
    output logic          proto_err
);
    acc_state_e    state, nxt;
    logic [AW-1:0] addr_lat;

    always_comb begin
        nxt = state;
        unique case (state)
            ACC_IDLE: begin
                if (host_sel) begin
                    if (!en_s)                 nxt = rw_s ? ACC_READ : ACC_WRITE;
                    else if (!ack_s && req_pend) nxt = ACC_DMA;
                end
            end
            ACC_READ, ACC_WRITE: if (!host_sel || en_s)  nxt = ACC_IDLE;
            ACC_DMA:             if (!host_sel || ack_s) nxt = ACC_IDLE;
            default:             nxt = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ACC_IDLE;
            addr_lat <= '0;
        end else begin
            state <= nxt;
            if (state == ACC_IDLE && nxt != ACC_IDLE) addr_lat <= addr_s;
        end
    end

    always_comb begin
        drive     = 1'b0;
        wr_stb    = 1'b0;
        proto_err = 1'b0;
        unique case (state)
            ACC_IDLE:  ;
            ACC_READ: begin
                drive     = 1'b1;
                proto_err = !rw_s;
            end
            ACC_WRITE: begin
                wr_stb    = en_s && host_sel;
                proto_err = rw_s;
            end
            ACC_DMA:   drive = 1'b1;
            default:   ;
        endcase
    end

    assign wr_addr = addr_lat;
    assign wr_data = data_s;
    assign rd_addr = addr_lat;

    assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
    assert_wr_after_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> en_s && $past(!en_s));
    assert_drive_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> $past(!en_s) || $past(!ack_s));
    assert_err_in_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(!en_s));
endmodule

// File: rtl/hpp_port_cfg.sv
`timescale 1ns/1ps
module hpp_port_cfg
    import hpp_pkg::*;
#(
    parameter int PINS = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_addr,
    input  logic [PINS-1:0] cfg_wdata,
    output logic [PINS-1:0] cfg_rdata,
    input  logic [PINS-1:0] pins_s,
    output logic [PINS-1:0] gpio_dir,
    output logic [PINS-1:0] gpio_dout,
    output logic            host_sel,
    output logic            gpio_sel
);
    mode_state_e mstate, mnxt;
    logic        mode_tgt;
    logic        mode_wr;

    assign mode_wr = cfg_we && (cfg_addr == CFG_MODE);

    always_comb begin
        mnxt = mstate;
        unique case (mstate)
            MODE_GPIO:  if (mode_wr &&  cfg_wdata[0]) mnxt = MODE_BLANK;
            MODE_HOST:  if (mode_wr && !cfg_wdata[0]) mnxt = MODE_BLANK;
            MODE_BLANK: mnxt = mode_tgt ? MODE_HOST : MODE_GPIO;
            default:    mnxt = MODE_GPIO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mstate    <= MODE_GPIO;
            mode_tgt  <= 1'b0;
            gpio_dir  <= '0;
            gpio_dout <= '0;
        end else begin
            mstate <= mnxt;
            if (mode_wr && mstate != MODE_BLANK) mode_tgt <= cfg_wdata[0];
            if (cfg_we && cfg_addr == CFG_DIR)  gpio_dir  <= cfg_wdata;
            if (cfg_we && cfg_addr == CFG_DATA) gpio_dout <= cfg_wdata;
        end
    end

    always_comb begin
        host_sel = (mstate == MODE_HOST);
        gpio_sel = (mstate == MODE_GPIO);
        unique case (cfg_addr)
            CFG_MODE: cfg_rdata = {{(PINS-1){1'b0}}, mode_tgt};
            CFG_DIR:  cfg_rdata = gpio_dir;
            CFG_DATA: cfg_rdata = (gpio_dir & gpio_dout) | (~gpio_dir & pins_s);
            default:  cfg_rdata = '0;
        endcase
    end

    assert_mode_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mstate != MODE_BLANK && cfg_wdata[0] != host_sel) |=> mstate == MODE_BLANK);
    assert_blank_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mstate == MODE_BLANK |=> mstate != MODE_BLANK);
endmodule

// File: rtl/host_pin_port.sv
`timescale 1ns/1ps
module host_pin_port
    import hpp_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DW+AW:0]       pad_i,
    output logic [DW+AW:0]       pad_o,
    output logic [DW+AW:0]       pad_oe,
    input  logic                 hen_n,
    input  logic                 hack_n,
    output logic                 hreq_n,
    input  logic                 req_pend,
    output logic [AW-1:0]        reg_rd_addr,
    input  logic [DW-1:0]        reg_rd_data,
    output logic                 reg_wr_stb,
    output logic [AW-1:0]        reg_wr_addr,
    output logic [DW-1:0]        reg_wr_data,
    output logic                 proto_err,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_addr,
    input  logic [DW+AW:0]       cfg_wdata,
    output logic [DW+AW:0]       cfg_rdata
);
    localparam int PINS   = DW + AW + 1;
    localparam int RW_BIT = PINS - 1;

    logic [PINS-1:0] pins_s, gpio_dir, gpio_dout;
    logic [1:0]      ctl_s;
    logic            host_sel, gpio_sel, drive;

    hpp_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pad_sync (
        .clk(clk), .rst_n(rst_n), .din(pad_i), .dout(pins_s));

    hpp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .din({hack_n, hen_n}), .dout(ctl_s));

    hpp_port_cfg #(.PINS(PINS)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .pins_s(pins_s),
        .gpio_dir(gpio_dir), .gpio_dout(gpio_dout),
        .host_sel(host_sel), .gpio_sel(gpio_sel));

    hpp_access_fsm #(.DW(DW), .AW(AW)) u_acc (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel),
        .en_s(ctl_s[0]), .ack_s(ctl_s[1]), .rw_s(pins_s[RW_BIT]),
        .addr_s(pins_s[DW +: AW]), .data_s(pins_s[DW-1:0]),
        .req_pend(req_pend), .drive(drive),
        .wr_stb(reg_wr_stb), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
        .rd_addr(reg_rd_addr), .proto_err(proto_err));

    always_comb begin
        pad_oe = '0;
        pad_o  = '0;
        if (gpio_sel) begin
            pad_oe = gpio_dir;
            pad_o  = gpio_dout;
        end else if (host_sel) begin
            pad_oe[DW-1:0] = {DW{drive}};
            pad_o[DW-1:0]  = reg_rd_data;
        end
    end

    assign hreq_n = !(host_sel && req_pend);

    assert_blank_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_sel && !gpio_sel) |-> pad_oe == '0);
    assert_host_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_sel |-> pad_oe[PINS-1:DW] == '0);
endmodule

// File: tb/tb_host_pin_port.sv
`timescale 1ns/1ps
module tb_host_pin_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] pad_i = '0;
    logic [11:0] pad_o, pad_oe;
    logic        hen_n = 1'b1, hack_n = 1'b1, hreq_n, req_pend = 1'b0;
    logic [2:0]  reg_rd_addr, reg_wr_addr;
    logic [7:0]  reg_rd_data, reg_wr_data;
    logic        reg_wr_stb, proto_err;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0, cfg_rdata;

    int checks = 0, fails = 0;
    int wr_cnt = 0, err_cnt = 0;
    logic [2:0] last_wa;
    logic [7:0] last_wd;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign reg_rd_data = {5'b10100, reg_rd_addr};

    host_pin_port dut (
        .clk(clk), .rst_n(rst_n), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe),
        .hen_n(hen_n), .hack_n(hack_n), .hreq_n(hreq_n), .req_pend(req_pend),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .reg_wr_stb(reg_wr_stb), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .proto_err(proto_err), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata));

    always @(posedge clk) begin
        if (rst_n && reg_wr_stb) begin
            wr_cnt++;
            last_wa = reg_wr_addr;
            last_wd = reg_wr_data;
        end
        if (rst_n && proto_err) err_cnt++;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [11:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] a, output logic [11:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic t_reset;
        logic [11:0] rd;
        req_pend = 1'b1;
        tick(1);
        check("R1", "oe after reset", pad_oe, 12'h000);
        check("R1", "req high after reset", hreq_n, 1'b1);
        check("R12", "req high in gpio mode", hreq_n, 1'b1);
        cfg_read(2'd0, rd);
        check("R1", "mode readback", rd, 12'h000);
        req_pend = 1'b0;
    endtask

    task automatic t_gpio;
        logic [11:0] rd;
        cfg_write(2'd1, 12'h0F0);
        cfg_write(2'd2, 12'hA5A);
        check("R8", "gpio oe", pad_oe, 12'h0F0);
        check("R8", "gpio out", pad_o, 12'hA5A);
        @(negedge clk);
        pad_i = 12'h3C3; hen_n = 1'b0;
        tick(4);
        check("R8", "enable ignored in gpio", pad_oe, 12'h0F0);
        cfg_read(2'd2, rd);
        check("R9", "mixed readback", rd, (12'h0F0 & 12'hA5A) | (~12'h0F0 & 12'h3C3));
        @(negedge clk);
        hen_n = 1'b1;
        tick(3);
    endtask

    task automatic t_mode_switch;
        cfg_write(2'd1, 12'hFFF);
        check("R8", "all outputs", pad_oe, 12'hFFF);
        cfg_write(2'd0, 12'h001);
        check("R10", "blank into host", pad_oe, 12'h000);
        tick(1);
        check("R4", "host idle no drive", pad_oe, 12'h000);
        @(negedge clk);
        pad_i = {1'b1, 3'd5, 8'h00}; hen_n = 1'b0;
        tick(4);
        check("R2", "read driving before switch", pad_oe, 12'h0FF);
        cfg_write(2'd0, 12'h000);
        check("R10", "blank into gpio", pad_oe, 12'h000);
        tick(1);
        check("R10", "gpio after blank", pad_oe, 12'hFFF);
        @(negedge clk);
        hen_n = 1'b1;
        cfg_write(2'd1, 12'h000);
        cfg_write(2'd0, 12'h001);
        tick(2);
    endtask

    task automatic t_read(input logic [2:0] a);
        @(negedge clk);
        pad_i = {1'b1, a, 8'h00}; hen_n = 1'b0;
        tick(1);
        check("R11", "no drive edge 1", pad_oe, 12'h000);
        tick(1);
        check("R11", "no drive edge 2", pad_oe, 12'h000);
        tick(1);
        check("R11", "drive at edge 3", pad_oe, 12'h0FF);
        check("R2", "read data", pad_o[7:0], {5'b10100, a});
        check("R6", "read address", reg_rd_addr, a);
        @(negedge clk);
        hen_n = 1'b1;
        tick(4);
        check("R4", "released after read", pad_oe, 12'h000);
    endtask

    task automatic t_write(input logic [2:0] a, input logic [7:0] d);
        int w0, e0;
        w0 = wr_cnt; e0 = err_cnt;
        @(negedge clk);
        pad_i = {1'b0, a, d}; hen_n = 1'b0;
        tick(4);
        check("R3", "write not driving", pad_oe, 12'h000);
        check("R3", "no strobe before enable rises", wr_cnt, w0);
        @(negedge clk);
        hen_n = 1'b1;
        tick(5);
        check("R3", "one strobe", wr_cnt, w0 + 1);
        check("R6", "write address", last_wa, a);
        check("R3", "write byte", last_wd, d);
        check("R7", "no error when stable", err_cnt, e0);
    endtask

    task automatic t_dma;
        @(negedge clk);
        req_pend = 1'b1;
        #1;
        check("R12", "req low in host", hreq_n, 1'b0);
        @(negedge clk);
        hack_n = 1'b0;
        tick(4);
        check("R5", "dma drive", pad_oe, 12'h0FF);
        @(negedge clk);
        hack_n = 1'b1;
        tick(4);
        check("R5", "dma release", pad_oe, 12'h000);
        @(negedge clk);
        req_pend = 1'b0;
        #1;
        check("R12", "req high without pending", hreq_n, 1'b1);
        @(negedge clk);
        hack_n = 1'b0;
        tick(4);
        check("R5", "ack without request ignored", pad_oe, 12'h000);
        @(negedge clk);
        hack_n = 1'b1;
        tick(3);
    endtask

    task automatic t_proto;
        int e0;
        @(negedge clk);
        pad_i = {1'b1, 3'd2, 8'h00}; hen_n = 1'b0;
        tick(4);
        e0 = err_cnt;
        check("R7", "no error while stable", proto_err, 1'b0);
        @(negedge clk);
        pad_i[11] = 1'b0;
        tick(4);
        check("R7", "error flagged", proto_err, 1'b1);
        check("R7", "error counted", err_cnt > e0, 1'b1);
        check("R7", "direction kept", pad_oe, 12'h0FF);
        @(negedge clk);
        hen_n = 1'b1;
        tick(4);
        check("R7", "error clears", proto_err, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gpio();
        t_mode_switch();
        t_read(3'd7);
        t_read(3'd0);
        t_write(3'd3, 8'h5C);
        t_write(3'd7, 8'hE1);
        t_dma();
        t_proto();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule